// File: doc/BRIEF.md
# Quota-Aware Replacement Victim Selector

This block picks which way of one set in a shared set-associative cache is evicted when a core misses. Each line carries the id of the core that filled it. The block counts how many valid lines in the set belong to the missing core and compares that count with the core's way quota. A core below its quota takes a line from another core. A core at or above its quota must replace one of its own lines. In both cases the least recently used candidate is chosen, so partitions drift toward their quotas one fill at a time.

An empty way is always used before any valid line is evicted. If the chosen pool has no candidate, the set's overall least recently used line is taken instead. Along with the victim, the block returns the owner id to write into that way and the set's updated recency ranks, with the victim made most recent. The choice is computed combinationally from the set state and registered once, so results appear on the clock edge after the miss strobe.

Top module: `vsel_victim_select`

## Requirements
- R1: `victim_valid` is high exactly in the cycle after a cycle with `miss_valid` high and is low otherwise. Reset (active-low `rst_n`, asynchronous) clears `victim_valid`, `victim_way`, `victim_owner` and `new_rank` to zero.
- R2: If any way has its `line_valid` bit low, the lowest-numbered such way is the victim, whatever the quotas and ownership.
- R3: With every way valid and the missing core owning fewer lines than its quota, the victim is the line owned by another core that has the largest recency rank. Rank 0 is most recent and rank NUM_WAYS-1 is least recent. The rank of way w is `lru_rank[w*WAY_W +: WAY_W]` and the owner of way w is `line_owner[w*CORE_W +: CORE_W]`.
- R4: With every way valid and the missing core owning at least its quota, the victim is that core's own line with the largest recency rank. The quota of core c is `core_quota[c*QUOTA_W +: QUOTA_W]`, unsigned.
- R5: If the pool chosen by R3 or R4 holds no line, the victim is the way with the largest rank in the whole set.
- R6: `victim_owner` equals the `miss_core` value that was sampled with the strobe.
- R7: `new_rank` gives the victim rank 0 and adds one to every way whose old rank was below the victim's old rank. All other ranks are unchanged.
- R8: Outside the result cycle, `victim_way`, `victim_owner` and `new_rank` keep the last result. Set-state inputs presented without a strobe do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss strobe: sample the set state this cycle |
| miss_core | input | CORE_W | Id of the missing core |
| line_valid | input | NUM_WAYS | Valid bit of each way |
| line_owner | input | NUM_WAYS*CORE_W | Owner core id of each way |
| lru_rank | input | NUM_WAYS*WAY_W | Recency rank of each way (0 = most recent) |
| core_quota | input | NUM_CORES*QUOTA_W | Granted way count for each core |
| victim_valid | output | 1 | Result strobe, one cycle after `miss_valid` |
| victim_way | output | WAY_W | Way to evict and fill |
| victim_owner | output | CORE_W | Owner id to store in the filled way |
| new_rank | output | NUM_WAYS*WAY_W | Recency ranks after the fill |

## Verification
A wrong ownership count or a flipped quota comparison shows at the ports in the very next result cycle. The victim then comes from the wrong pool, so its owner in the sampled set disagrees with what the requester's standing calls for. A wrong recency comparison shows the same cycle as a victim that is not the oldest line in its pool, and as a rank vector that is no longer a permutation with the victim at zero. A register that loads without a strobe shows in the following idle cycle as an output that changes even though no miss was presented.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    // Which rule produced the victim
    typedef enum logic [1:0] {
        PICK_EMPTY    = 2'd0,
        PICK_POOL     = 2'd1,
        PICK_FALLBACK = 2'd2
    } pick_kind_e;

endpackage

// File: rtl/vsel_owner_mask.sv
module vsel_owner_mask #(
    parameter int NUM_WAYS = 8,
    parameter int CORE_W   = 2,
    localparam int CNT_W   = $clog2(NUM_WAYS) + 1
) (
    input  logic [NUM_WAYS-1:0]        line_valid,
    input  logic [NUM_WAYS*CORE_W-1:0] line_owner,
    input  logic [CORE_W-1:0]          req_core,
    output logic [NUM_WAYS-1:0]        own_mask,
    output logic [NUM_WAYS-1:0]        other_mask,
    output logic [CNT_W-1:0]           own_count
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic mine;
        assign mine          = (line_owner[w*CORE_W +: CORE_W] == req_core);
        assign own_mask[w]   = line_valid[w] & mine;
        assign other_mask[w] = line_valid[w] & ~mine;
    end

    always_comb begin
        own_count = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            own_count = own_count + CNT_W'(own_mask[w]);
        end
    end
endmodule

// File: rtl/vsel_oldest.sv
module vsel_oldest #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]       cand,
    input  logic [NUM_WAYS*WAY_W-1:0] ranks,
    output logic                      found,
    output logic [WAY_W-1:0]          way
);
    logic [WAY_W-1:0] best_rank;

    always_comb begin
        found     = 1'b0;
        way       = '0;
        best_rank = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (cand[w] && (!found || ranks[w*WAY_W +: WAY_W] > best_rank)) begin
                found     = 1'b1;
                way       = WAY_W'(w);
                best_rank = ranks[w*WAY_W +: WAY_W];
            end
        end
    end
endmodule

// File: rtl/vsel_rank_update.sv
module vsel_rank_update #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WAY_W-1:0] ranks_in,
    input  logic [WAY_W-1:0]          touch_way,
    output logic [NUM_WAYS*WAY_W-1:0] ranks_out
);
    logic [WAY_W-1:0] touch_rank;
    assign touch_rank = ranks_in[touch_way*WAY_W +: WAY_W];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [WAY_W-1:0] cur;
        assign cur = ranks_in[w*WAY_W +: WAY_W];
        always_comb begin
            if (WAY_W'(w) == touch_way) begin
                ranks_out[w*WAY_W +: WAY_W] = '0;
            end else if (cur < touch_rank) begin
                ranks_out[w*WAY_W +: WAY_W] = cur + WAY_W'(1);
            end else begin
                ranks_out[w*WAY_W +: WAY_W] = cur;
            end
        end
    end
endmodule

// File: rtl/vsel_victim_select.sv
module vsel_victim_select #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_CORES = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int QUOTA_W  = WAY_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         miss_valid,
    input  logic [CORE_W-1:0]            miss_core,
    input  logic [NUM_WAYS-1:0]          line_valid,
    input  logic [NUM_WAYS*CORE_W-1:0]   line_owner,
    input  logic [NUM_WAYS*WAY_W-1:0]    lru_rank,
    input  logic [NUM_CORES*QUOTA_W-1:0] core_quota,
    output logic                         victim_valid,
    output logic [WAY_W-1:0]             victim_way,
    output logic [CORE_W-1:0]            victim_owner,
    output logic [NUM_WAYS*WAY_W-1:0]    new_rank
);
    import vsel_pkg::*;

    typedef struct packed {
        logic                      vld;
        logic [WAY_W-1:0]          way;
        logic [CORE_W-1:0]         owner;
        logic [NUM_WAYS*WAY_W-1:0] ranks;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_WAYS-1:0] own_mask, other_mask, pool_mask;
    logic [QUOTA_W-1:0]  own_count, quota_sel;
    logic                under_quota;
    logic                pool_found, all_found;
    logic [WAY_W-1:0]    pool_way, all_way;
    logic                empty_found;
    logic [WAY_W-1:0]    empty_way;
    logic [WAY_W-1:0]    pick_way_d;
    pick_kind_e          pick_kind_d;
    logic [NUM_WAYS*WAY_W-1:0] ranks_upd;

    vsel_owner_mask #(.NUM_WAYS(NUM_WAYS), .CORE_W(CORE_W)) u_mask (
        .line_valid (line_valid),
        .line_owner (line_owner),
        .req_core   (miss_core),
        .own_mask   (own_mask),
        .other_mask (other_mask),
        .own_count  (own_count)
    );

    assign quota_sel   = core_quota[miss_core*QUOTA_W +: QUOTA_W];
    assign under_quota = (own_count < quota_sel);
    assign pool_mask   = under_quota ? other_mask : own_mask;

    vsel_oldest #(.NUM_WAYS(NUM_WAYS)) u_pool_oldest (
        .cand  (pool_mask),
        .ranks (lru_rank),
        .found (pool_found),
        .way   (pool_way)
    );

    vsel_oldest #(.NUM_WAYS(NUM_WAYS)) u_set_oldest (
        .cand  ({NUM_WAYS{1'b1}}),
        .ranks (lru_rank),
        .found (all_found),
        .way   (all_way)
    );

    // Lowest-numbered empty way
    always_comb begin
        empty_found = 1'b0;
        empty_way   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!line_valid[w]) begin
                empty_found = 1'b1;
                empty_way   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        if (empty_found) begin
            pick_kind_d = PICK_EMPTY;
            pick_way_d  = empty_way;
        end else if (pool_found) begin
            pick_kind_d = PICK_POOL;
            pick_way_d  = pool_way;
        end else begin
            pick_kind_d = PICK_FALLBACK;
            pick_way_d  = all_found ? all_way : '0;
        end
    end

    vsel_rank_update #(.NUM_WAYS(NUM_WAYS)) u_rank (
        .ranks_in  (lru_rank),
        .touch_way (pick_way_d),
        .ranks_out (ranks_upd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (miss_valid && (pick_kind_d inside {PICK_EMPTY, PICK_POOL, PICK_FALLBACK})) begin
            st_d.vld   = 1'b1;
            st_d.way   = pick_way_d;
            st_d.owner = miss_core;
            st_d.ranks = ranks_upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign victim_valid = st_q.vld;
    assign victim_way   = st_q.way;
    assign victim_owner = st_q.owner;
    assign new_rank     = st_q.ranks;
endmodule

// File: rtl/vsel_victim_select_chk.sv
module vsel_victim_select_chk #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_CORES = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int QUOTA_W  = WAY_W + 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         miss_valid,
    input logic [CORE_W-1:0]            miss_core,
    input logic [NUM_WAYS-1:0]          line_valid,
    input logic [NUM_WAYS*CORE_W-1:0]   line_owner,
    input logic [NUM_WAYS*WAY_W-1:0]    lru_rank,
    input logic [NUM_CORES*QUOTA_W-1:0] core_quota,
    input logic                         victim_valid,
    input logic [WAY_W-1:0]             victim_way,
    input logic [CORE_W-1:0]            victim_owner,
    input logic [NUM_WAYS*WAY_W-1:0]    new_rank
);
    // Set state captured with the strobe
    logic [NUM_WAYS-1:0]        cap_valid;
    logic [NUM_WAYS*CORE_W-1:0] cap_owner;
    logic [CORE_W-1:0]          cap_core;
    logic [QUOTA_W-1:0]         cap_quota;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= '0;
            cap_owner <= '0;
            cap_core  <= '0;
            cap_quota <= '0;
        end else if (miss_valid) begin
            cap_valid <= line_valid;
            cap_owner <= line_owner;
            cap_core  <= miss_core;
            cap_quota <= core_quota[miss_core*QUOTA_W +: QUOTA_W];
        end
    end

    int   n_own;
    logic has_other, is_under, victim_mine, all_full;
    logic [WAY_W-1:0] rank_at_victim;
    logic [NUM_WAYS-1:0] zero_rank;

    always_comb begin
        n_own     = 0;
        has_other = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (cap_owner[w*CORE_W +: CORE_W] == cap_core) n_own = n_own + 1;
            else has_other = 1'b1;
        end
        for (int w = 0; w < NUM_WAYS; w++) begin
            zero_rank[w] = (new_rank[w*WAY_W +: WAY_W] == '0);
        end
    end

    assign is_under       = (n_own < int'(cap_quota));
    assign all_full       = &cap_valid;
    assign victim_mine    = (cap_owner[victim_way*CORE_W +: CORE_W] == cap_core);
    assign rank_at_victim = new_rank[victim_way*WAY_W +: WAY_W];

    a_r1_result_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid == $past(miss_valid));

    a_r2_empty_way_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !all_full) |-> !cap_valid[victim_way]);

    a_r3_under_takes_other: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && all_full && is_under && has_other) |-> !victim_mine);

    a_r4_at_quota_takes_own: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && all_full && !is_under && n_own > 0) |-> victim_mine);

    a_r6_owner_is_requester: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> victim_owner == $past(miss_core));

    a_r7_victim_most_recent: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (rank_at_victim == '0 && $countones(zero_rank) == 1));

    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(miss_valid) |-> ($stable(victim_way) && $stable(victim_owner) && $stable(new_rank)));
endmodule

bind vsel_victim_select vsel_victim_select_chk #(
    .NUM_WAYS  (NUM_WAYS),
    .NUM_CORES (NUM_CORES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_core    (miss_core),
    .line_valid   (line_valid),
    .line_owner   (line_owner),
    .lru_rank     (lru_rank),
    .core_quota   (core_quota),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .victim_owner (victim_owner),
    .new_rank     (new_rank)
);

// File: tb/vsel_victim_select_test.sv
module vsel_victim_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int NC = 4;
    localparam int WW = 3;
    localparam int CW = 2;
    localparam int QW = 4;

    typedef struct packed {
        logic [NW-1:0]    valid;
        logic [NW*CW-1:0] owners;   // way w at [2w+1:2w]
        logic             rev;      // 0: rank w = w, 1: rank w = 7-w
        logic [CW-1:0]    core;
        logic [NC*QW-1:0] quotas;   // core c at [4c+3:4c]
        logic [WW-1:0]    exp_way;
        logic [3:0]       req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{8'b1111_0111, 16'h0000, 1'b0, 2'd0, 16'h0000, 3'd3, 4'd2}, // R2 single empty way
        '{8'b0101_0111, 16'h0000, 1'b1, 2'd1, 16'h00F0, 3'd3, 4'd2}, // R2 lowest empty way
        '{8'b1011_1111, 16'h555D, 1'b0, 2'd3, 16'h1000, 3'd6, 4'd2}, // R2 beats quota rule
        '{8'hFF,        16'h0055, 1'b0, 2'd0, 16'h0006, 3'd3, 4'd3}, // R3 under quota
        '{8'hFF,        16'h0055, 1'b1, 2'd0, 16'h0008, 3'd0, 4'd3}, // R3 under, reversed ranks
        '{8'hFF,        16'h1555, 1'b0, 2'd0, 16'h0002, 3'd6, 4'd3}, // R3 skips own oldest line
        '{8'hFF,        16'h0055, 1'b0, 2'd0, 16'h0004, 3'd7, 4'd4}, // R4 exactly at quota
        '{8'hFF,        16'h0055, 1'b1, 2'd0, 16'h0003, 3'd4, 4'd4}, // R4 over quota, reversed
        '{8'hFF,        16'h555D, 1'b0, 2'd3, 16'h1000, 3'd1, 4'd4}, // R4 single own line
        '{8'hFF,        16'hAAAA, 1'b1, 2'd2, 16'h0900, 3'd0, 4'd5}, // R5 under, owns all
        '{8'hFF,        16'h5555, 1'b0, 2'd3, 16'h0000, 3'd7, 4'd5}  // R5 zero quota, owns none
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [CW-1:0]     miss_core = '0;
    logic [NW-1:0]     line_valid = '0;
    logic [NW*CW-1:0]  line_owner = '0;
    logic [NW*WW-1:0]  lru_rank = '0;
    logic [NC*QW-1:0]  core_quota = '0;
    logic              victim_valid;
    logic [WW-1:0]     victim_way;
    logic [CW-1:0]     victim_owner;
    logic [NW*WW-1:0]  new_rank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsel_victim_select uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_core    (miss_core),
        .line_valid   (line_valid),
        .line_owner   (line_owner),
        .lru_rank     (lru_rank),
        .core_quota   (core_quota),
        .victim_valid (victim_valid),
        .victim_way   (victim_way),
        .victim_owner (victim_owner),
        .new_rank     (new_rank)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NW*WW-1:0] base_ranks(logic rev);
        logic [NW*WW-1:0] r;
        for (int w = 0; w < NW; w++) r[w*WW +: WW] = rev ? WW'(NW-1-w) : WW'(w);
        return r;
    endfunction

    function automatic logic [NW*WW-1:0] after_fill(logic [NW*WW-1:0] r, int v);
        logic [NW*WW-1:0] o;
        logic [WW-1:0] rv;
        rv = r[v*WW +: WW];
        for (int w = 0; w < NW; w++) begin
            if (w == v)                  o[w*WW +: WW] = '0;
            else if (r[w*WW +: WW] < rv) o[w*WW +: WW] = r[w*WW +: WW] + 1'b1;
            else                         o[w*WW +: WW] = r[w*WW +: WW];
        end
        return o;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 32'(victim_valid), 0, "valid in reset");
        check("R1", 32'(victim_way), 0, "way in reset");
        check("R1", 32'(new_rank), 0, "ranks in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(victim_valid), 0, "valid idle after reset");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            line_valid = VECS[i].valid;
            line_owner = VECS[i].owners;
            lru_rank   = base_ranks(VECS[i].rev);
            miss_core  = VECS[i].core;
            core_quota = VECS[i].quotas;
            miss_valid = 1'b1;
            @(negedge clk);
            miss_valid = 1'b0;
            check("R1", 32'(victim_valid), 1, "valid after strobe");
            check(tag, 32'(victim_way), 32'(VECS[i].exp_way), $sformatf("victim way vec %0d", i));
            check("R6", 32'(victim_owner), 32'(VECS[i].core), "new owner");
            check("R7", 32'(new_rank), 32'(after_fill(base_ranks(VECS[i].rev), int'(VECS[i].exp_way))), "new ranks");
            // R8: change the set state with no strobe
            line_valid = 8'h00;
            miss_core  = ~VECS[i].core;
            lru_rank   = base_ranks(~VECS[i].rev);
            @(negedge clk);
            check("R1", 32'(victim_valid), 0, "valid drops");
            check("R8", 32'(victim_way), 32'(VECS[i].exp_way), "way held");
            check("R8", 32'(victim_owner), 32'(VECS[i].core), "owner held");
        end

        // R1: back-to-back strobes, each result one cycle later
        line_valid = 8'b1111_1110; miss_core = 2'd1; lru_rank = base_ranks(1'b0);
        line_owner = 16'h0000; core_quota = 16'h0000;
        miss_valid = 1'b1;
        @(negedge clk);
        check("R2", 32'(victim_way), 0, "first of pair");
        check("R6", 32'(victim_owner), 1, "first owner");
        line_valid = 8'hFF; miss_core = 2'd2;   // owns none, quota 0 -> own pool empty
        @(negedge clk);
        miss_valid = 1'b0;
        check("R1", 32'(victim_valid), 1, "second of pair valid");
        check("R5", 32'(victim_way), 7, "second of pair way");
        check("R6", 32'(victim_owner), 2, "second owner");

        // R1: reset in the middle clears the outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 32'(victim_way), 0, "way cleared by reset");
        check("R1", 32'(victim_owner), 0, "owner cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(victim_valid), 0, "valid after second reset");

        finish_run();
    end
endmodule